// File: doc/BRIEF.md
# Filtered Cell-Voltage Peak and Droop Detector

This block watches the voltage of a single charging cell, as seen through an external ADC, and decides when the voltage has started to fall after reaching its maximum. A drop like this marks the end of fast charge. The interval between averaged samples is long and fixed. At the start of each interval the block issues a burst of evenly spaced conversion requests and averages the results into one filtered sample. The burst length depends on the selected detection mode, and each length is chosen so that the averaging window cancels mains ripple.

Every filtered sample is compared with the highest filtered sample seen since the last clear. The clear is pulsed by the charge controller when fast charge begins. If the sample has fallen below that peak by at least the mode's threshold, the block raises a one-cycle termination request. The request is only raised when the sample lies inside the valid voltage band and the hold-off mask is low. All thresholds and band edges are parameters in ADC LSBs.

Top module: `cell_slope_detect`

## Requirements
- R1: Counting ticks of `tick_i`, a sampling window opens once every SAMPLE_DIV ticks. Inside a window, `conv_req_o` pulses for one cycle once every CONV_DIV ticks. The window closes after 32 requests when `mode_i`=0 (peak mode) and after 16 requests when `mode_i`=1 (droop mode).
- R2: `avg_o` is the floor of the mean of the conversions accepted in the window, computed as a right shift by 5 (mode 0) or by 4 (mode 1). In the cycle after the last conversion of the window is accepted, `avg_o` takes the new value and `avg_valid_o` is high for that one cycle. `avg_o` holds its value at all other times.
- R3: The mode in effect for a window is the value of `mode_i` when the window opens. A change of `mode_i` while the window is open does not change that window's length or shift.
- R4: Strobes on `adc_valid_i` are ignored once the window's last conversion has been accepted, until the next window opens.
- R5: `clear_i` empties the tracked peak and forces `term_o` low on the next cycle. The first sample after a clear becomes the peak. After that, the peak only changes when a sample is strictly higher than it.
- R6: In droop mode (1), `term_o` pulses when (peak − sample) ≥ NDV_DROP. The default is 12 LSB.
- R7: In peak mode (0), `term_o` pulses when (peak − sample) ≥ PEAK_DROP. The default is 3 LSB.
- R8: A termination request is only raised for a sample strictly between BAND_LO and BAND_HI. The defaults are 1000 and 2000 LSB.
- R9: While `holdoff_i` is high, no termination request is raised. Samples taken during the hold-off still update the peak.
- R10: `term_o` is a single-cycle pulse in the cycle after `avg_valid_o`. During reset, `term_o`, `avg_valid_o`, `conv_req_o` and `avg_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick that drives both dividers |
| adc_data_i | input | ADC_W | Conversion result |
| adc_valid_i | input | 1 | Conversion result strobe |
| mode_i | input | 1 | 0 = peak mode (32-sample average), 1 = droop mode (16-sample average) |
| clear_i | input | 1 | Start-of-charge pulse that empties the tracked peak |
| holdoff_i | input | 1 | Masks termination requests |
| conv_req_o | output | 1 | Conversion request pulse |
| avg_o | output | ADC_W | Latest filtered sample |
| avg_valid_o | output | 1 | One-cycle strobe marking a new filtered sample |
| term_o | output | 1 | One-cycle termination request |

## Verification
The bench builds the block with CONV_DIV=2 and SAMPLE_DIV=100, and holds `tick_i` high. A full 32-request window therefore fits in about 66 cycles, and a new filtered sample arrives every 100 cycles. This lets a long sequence of samples test the peak tracking. The thresholds and band edges stay at their defaults, so the stimulus can hit exact droop boundaries: 11 versus 12 LSB, 2 versus 3 LSB, and samples at the band edges. The ADC model returns a ramp indexed by request number. The ramp's mean differs between 16-sample and 32-sample windows, which shows the window length and the latched mode in the average itself.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic {
    MODE_PEAK  = 1'b0,
    MODE_DROOP = 1'b1
  } csd_mode_e;

  function automatic int csd_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/csd_sched.sv
module csd_sched
  import csd_pkg::*;
#(
  parameter int SAMPLE_DIV = 100,
  parameter int CONV_DIV   = 2,
  parameter int PEAK_LOG2  = 5,
  parameter int NDV_LOG2   = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      mode_i,
  output logic      start_o,
  output logic      conv_req_o,
  output csd_mode_e win_mode_o
);
  localparam int SW = $clog2(SAMPLE_DIV + 1);
  localparam int CW = $clog2(CONV_DIV + 1);
  localparam int NW = csd_max(PEAK_LOG2, NDV_LOG2) + 1;

  logic [SW-1:0] samp_q, samp_d;
  logic [CW-1:0] conv_q, conv_d;
  logic [NW-1:0] nreq_q, nreq_d, nlen;
  logic          open_q, open_d, req_d, wrap;
  csd_mode_e     mode_q, mode_d;

  always_comb begin
    wrap   = tick_i && (samp_q == SW'(SAMPLE_DIV - 1));
    samp_d = samp_q;
    if (tick_i) samp_d = wrap ? '0 : samp_q + SW'(1);
    nlen   = (mode_q == MODE_PEAK) ? NW'(1 << PEAK_LOG2) : NW'(1 << NDV_LOG2);
    open_d = open_q;
    conv_d = conv_q;
    nreq_d = nreq_q;
    mode_d = mode_q;
    req_d  = 1'b0;
    if (wrap) begin
      open_d = 1'b1;
      conv_d = '0;
      nreq_d = '0;
      mode_d = csd_mode_e'(mode_i);
    end else if (open_q && tick_i) begin
      if (conv_q == '0) begin
        req_d  = 1'b1;
        nreq_d = nreq_q + NW'(1);
        if (nreq_d == nlen) open_d = 1'b0;
      end
      conv_d = (conv_q == CW'(CONV_DIV - 1)) ? '0 : conv_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      conv_q  <= '0;
      nreq_q  <= '0;
      open_q  <= 1'b0;
      mode_q  <= MODE_PEAK;
      start_o <= 1'b0;
      conv_req_o <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      conv_q  <= conv_d;
      nreq_q  <= nreq_d;
      open_q  <= open_d;
      mode_q  <= mode_d;
      start_o <= wrap;
      conv_req_o <= req_d;
    end
  end

  assign win_mode_o = mode_q;
endmodule

// File: rtl/csd_avg.sv
module csd_avg
  import csd_pkg::*;
#(
  parameter int ADC_W     = 12,
  parameter int PEAK_LOG2 = 5,
  parameter int NDV_LOG2  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  csd_mode_e        mode_i,
  input  logic             valid_i,
  input  logic [ADC_W-1:0] data_i,
  output logic [ADC_W-1:0] avg_o,
  output logic             avg_valid_o,
  output csd_mode_e        avg_mode_o
);
  localparam int MAXL = csd_max(PEAK_LOG2, NDV_LOG2);
  localparam int AW   = ADC_W + MAXL;
  localparam int NW   = MAXL + 1;

  logic [AW-1:0]    acc_q, acc_d, sum;
  logic [NW-1:0]    cnt_q, cnt_d, nlen;
  logic             armed_q, armed_d, done_d;
  logic [ADC_W-1:0] avg_d;
  csd_mode_e        omode_d;

  always_comb begin
    nlen    = (mode_i == MODE_PEAK) ? NW'(1 << PEAK_LOG2) : NW'(1 << NDV_LOG2);
    sum     = acc_q + AW'(data_i);
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    done_d  = 1'b0;
    avg_d   = avg_o;
    omode_d = avg_mode_o;
    if (start_i) begin
      acc_d   = '0;
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (armed_q && valid_i) begin
      if (cnt_q == nlen - NW'(1)) begin
        done_d  = 1'b1;
        armed_d = 1'b0;
        omode_d = mode_i;
        avg_d   = (mode_i == MODE_PEAK) ? ADC_W'(sum >> PEAK_LOG2)
                                        : ADC_W'(sum >> NDV_LOG2);
      end else begin
        acc_d = sum;
        cnt_d = cnt_q + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      armed_q     <= 1'b0;
      avg_o       <= '0;
      avg_valid_o <= 1'b0;
      avg_mode_o  <= MODE_PEAK;
    end else begin
      acc_q       <= acc_d;
      cnt_q       <= cnt_d;
      armed_q     <= armed_d;
      avg_o       <= avg_d;
      avg_valid_o <= done_d;
      avg_mode_o  <= omode_d;
    end
  end
endmodule

// File: rtl/csd_peak.sv
module csd_peak
  import csd_pkg::*;
#(
  parameter int ADC_W     = 12,
  parameter int PEAK_DROP = 3,
  parameter int NDV_DROP  = 12,
  parameter int BAND_LO   = 1000,
  parameter int BAND_HI   = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [ADC_W-1:0] avg_i,
  input  csd_mode_e        mode_i,
  input  logic             clear_i,
  input  logic             holdoff_i,
  output logic             term_o
);
  logic [ADC_W-1:0] peak_q, peak_d, fall, thr;
  logic             have_q, have_d, term_d, in_band, dropped;

  always_comb begin
    thr     = (mode_i == MODE_PEAK) ? ADC_W'(PEAK_DROP) : ADC_W'(NDV_DROP);
    fall    = peak_q - avg_i;
    in_band = (avg_i > ADC_W'(BAND_LO)) && (avg_i < ADC_W'(BAND_HI));
    dropped = have_q && (peak_q >= avg_i) && (fall >= thr);
    peak_d  = peak_q;
    have_d  = have_q;
    term_d  = 1'b0;
    if (clear_i) begin
      peak_d = '0;
      have_d = 1'b0;
    end else if (valid_i) begin
      if (!have_q || (avg_i > peak_q)) begin
        peak_d = avg_i;
        have_d = 1'b1;
      end
      term_d = dropped && in_band && !holdoff_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
      have_q <= 1'b0;
      term_o <= 1'b0;
    end else begin
      peak_q <= peak_d;
      have_q <= have_d;
      term_o <= term_d;
    end
  end
endmodule

// File: rtl/cell_slope_detect.sv
module cell_slope_detect
  import csd_pkg::*;
#(
  parameter int ADC_W      = 12,
  parameter int CONV_DIV   = 57,
  parameter int SAMPLE_DIV = 17_000_000,
  parameter int PEAK_LOG2  = 5,
  parameter int NDV_LOG2   = 4,
  parameter int PEAK_DROP  = 3,
  parameter int NDV_DROP   = 12,
  parameter int BAND_LO    = 1000,
  parameter int BAND_HI    = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic             adc_valid_i,
  input  logic             mode_i,
  input  logic             clear_i,
  input  logic             holdoff_i,
  output logic             conv_req_o,
  output logic [ADC_W-1:0] avg_o,
  output logic             avg_valid_o,
  output logic             term_o
);
  logic      win_start;
  csd_mode_e win_mode, avg_mode;

  csd_sched #(
    .SAMPLE_DIV(SAMPLE_DIV), .CONV_DIV(CONV_DIV),
    .PEAK_LOG2(PEAK_LOG2), .NDV_LOG2(NDV_LOG2)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i),
    .start_o(win_start), .conv_req_o(conv_req_o), .win_mode_o(win_mode)
  );

  csd_avg #(
    .ADC_W(ADC_W), .PEAK_LOG2(PEAK_LOG2), .NDV_LOG2(NDV_LOG2)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .start_i(win_start), .mode_i(win_mode),
    .valid_i(adc_valid_i), .data_i(adc_data_i),
    .avg_o(avg_o), .avg_valid_o(avg_valid_o), .avg_mode_o(avg_mode)
  );

  csd_peak #(
    .ADC_W(ADC_W), .PEAK_DROP(PEAK_DROP), .NDV_DROP(NDV_DROP),
    .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)
  ) u_peak (
    .clk(clk), .rst_n(rst_n), .valid_i(avg_valid_o), .avg_i(avg_o),
    .mode_i(avg_mode), .clear_i(clear_i), .holdoff_i(holdoff_i),
    .term_o(term_o)
  );
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int ADC_W   = 12,
  parameter int BAND_LO = 1000,
  parameter int BAND_HI = 2000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             holdoff_i,
  input logic [ADC_W-1:0] avg_o,
  input logic             avg_valid_o,
  input logic             term_o
);
  p_term_follows_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> $past(avg_valid_o));

  p_term_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |=> !term_o);

  p_term_in_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> ((avg_o > ADC_W'(BAND_LO)) && (avg_o < ADC_W'(BAND_HI))));

  p_term_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> !$past(holdoff_i));

  p_term_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> !$past(clear_i));

  p_avg_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_valid_o |-> $stable(avg_o));
endmodule

bind cell_slope_detect csd_checker #(
  .ADC_W(ADC_W), .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .holdoff_i(holdoff_i),
  .avg_o(avg_o), .avg_valid_o(avg_valid_o), .term_o(term_o)
);

// File: tb/cell_slope_detect_bench.sv
`timescale 1ns/1ps
module cell_slope_detect_bench;
  localparam int ADC_W = 12;
  localparam int NVEC  = 19;
  // {mode, holdoff, clear, ramp, base[12], exp_avg[12], exp_term}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b1,1'b0,12'd1500,12'd1500,1'b0}, // R5 first sample becomes peak
    {1'b1,1'b0,1'b0,1'b0,12'd1510,12'd1510,1'b0}, // R5 higher sample raises peak
    {1'b1,1'b0,1'b0,1'b0,12'd1499,12'd1499,1'b0}, // R6 droop 11 below threshold
    {1'b1,1'b0,1'b0,1'b0,12'd1498,12'd1498,1'b1}, // R6 droop exactly 12
    {1'b1,1'b1,1'b0,1'b0,12'd1400,12'd1400,1'b0}, // R9 masked
    {1'b1,1'b1,1'b0,1'b0,12'd1600,12'd1600,1'b0}, // R9 peak still tracked
    {1'b1,1'b0,1'b0,1'b0,12'd1588,12'd1588,1'b1}, // R9 droop from masked peak
    {1'b0,1'b0,1'b1,1'b0,12'd1500,12'd1500,1'b0}, // R5 clear restarts tracking
    {1'b0,1'b0,1'b0,1'b0,12'd1498,12'd1498,1'b0}, // R7 drop 2
    {1'b0,1'b0,1'b0,1'b0,12'd1497,12'd1497,1'b1}, // R7 drop exactly 3
    {1'b0,1'b0,1'b0,1'b0,12'd2100,12'd2100,1'b0}, // R8 above band, peak rises
    {1'b0,1'b0,1'b0,1'b0,12'd2000,12'd2000,1'b0}, // R8 upper edge excluded
    {1'b0,1'b0,1'b0,1'b0,12'd1990,12'd1990,1'b1}, // R8 inside band
    {1'b0,1'b0,1'b1,1'b0,12'd1000,12'd1000,1'b0}, // R5 clear, lower edge sample
    {1'b0,1'b0,1'b0,1'b1,12'd1200,12'd1215,1'b0}, // R2 32-sample ramp mean
    {1'b1,1'b0,1'b0,1'b1,12'd1200,12'd1207,1'b0}, // R2 16-sample ramp mean, droop 8
    {1'b1,1'b0,1'b0,1'b0,12'd1203,12'd1203,1'b1}, // R6 droop 12 from 1215; R5 peak held
    {1'b1,1'b0,1'b0,1'b0,12'd1001,12'd1001,1'b1}, // R8 just inside lower edge
    {1'b1,1'b0,1'b0,1'b0,12'd1000,12'd1000,1'b0}  // R8 lower edge excluded
  };

  logic clk, rst_n, tick, adc_valid, mode, clear, holdoff;
  logic [ADC_W-1:0] adc_data, avg;
  logic conv_req, avg_valid, term;

  int tests = 0, fails = 0;
  int base = 0, ramp = 0, idx = 0, win_reqs = 0;
  bit junk = 0;

  cell_slope_detect #(.ADC_W(ADC_W), .CONV_DIV(2), .SAMPLE_DIV(100)) u_cell_slope_detect (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .adc_data_i(adc_data),
    .adc_valid_i(adc_valid), .mode_i(mode), .clear_i(clear), .holdoff_i(holdoff),
    .conv_req_o(conv_req), .avg_o(avg), .avg_valid_o(avg_valid), .term_o(term)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ADC model: answers each request on the following edge with base + ramp*index
  initial begin
    adc_valid = 1'b0;
    adc_data  = '0;
    forever begin
      @(negedge clk);
      if (avg_valid) begin
        win_reqs = idx;
        idx = 0;
      end
      if (conv_req) begin
        adc_valid = 1'b1;
        adc_data  = ADC_W'(base + ramp * idx);
        idx++;
      end else if (junk) begin
        adc_valid = 1'b1;
        adc_data  = 12'd4000;
      end else begin
        adc_valid = 1'b0;
      end
    end
  end

  task automatic sample(input bit m, input bit h, input bit c, input bit r,
                        input int b, input int exp_avg, input bit exp_term,
                        input bit late_flip);
    int n;
    @(negedge clk);
    mode = m; holdoff = h; base = b; ramp = r ? 1 : 0;
    if (c) begin
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
    end
    if (late_flip) begin
      n = 0;
      while (!conv_req && n < 500) begin @(negedge clk); n++; end
      mode = ~m; // R3: change while window open
    end
    n = 0;
    while (!avg_valid && n < 500) begin @(negedge clk); n++; end
    chk("R2 avg", int'(avg), exp_avg);
    @(negedge clk);
    chk(h ? "R9 term" : (m ? "R6 term" : "R7 term"), int'(term), int'(exp_term));
    chk("R1 requests per window", win_reqs, m ? 16 : 32);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; mode = 1'b0; clear = 1'b0; holdoff = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 term in reset", int'(term), 0);
    chk("R10 avg_valid in reset", int'(avg_valid), 0);
    chk("R10 conv_req in reset", int'(conv_req), 0);
    chk("R10 avg in reset", int'(avg), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      sample(VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25],
             int'(VEC[i][24:13]), int'(VEC[i][12:1]), VEC[i][0], 1'b0);

    // R3: mode latched at window opening; flip to droop mid-window, expect 32-sample mean
    sample(1'b0, 1'b0, 1'b0, 1'b1, 1300, 1315, 1'b0, 1'b1);

    // R4: stray strobes between windows are ignored
    @(negedge clk);
    junk = 1'b1;
    repeat (10) @(negedge clk);
    junk = 1'b0;
    sample(1'b1, 1'b0, 1'b0, 1'b0, 1500, 1500, 1'b0, 1'b0);
    // R10 single-cycle pulse: next cycle after the check is low again
    @(negedge clk);
    chk("R10 term idle", int'(term), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule